// File: doc/BRIEF.md
# Switchable ROM Bank Controller with Nibble-Wide Work RAM

This block sits between a CPU address bus and a cartridge. It translates 16-bit CPU read addresses into a physical ROM address for an external ROM array. It also serves a small internal scratch RAM. Two control registers live in the low 16 KiB of the address space, and address bit 8 alone picks which of the two a write reaches. One register gates access to the RAM. The other is a 4-bit bank number that selects which 16 KiB ROM page appears in the upper half of the ROM window.

The internal RAM has 512 cells, each 4 bits wide. It is indexed by the low nine address bits, so it repeats throughout every address at or above 0xA000. The RAM-gate is a two-state machine with states `RAM_LOCKED` and `RAM_OPEN`. The transition `UNLOCK` (`RAM_LOCKED` to `RAM_OPEN`) fires on a gate write of exactly 0x0A. The transition `LOCK` (`RAM_OPEN` to `RAM_LOCKED`) fires on a gate write of any other value. Every other case is a hold in the current state.

RAM reads are synchronous: the byte appears on `rd_data` in the cycle after the read strobe. ROM addressing is combinational. Reads in 0x8000–0x9FFF belong to nobody and are flagged as open bus.

Top module: `nibble_bank_ctrl`

## Requirements
- R1: After reset the bank register holds 1, the gate is in `RAM_LOCKED`, and `rd_data` reads 0xFF.
- R2: A write with cpu_addr[15:14]=00 and cpu_addr[8]=0 is a gate write. Data of exactly 0x0A moves the gate to `RAM_OPEN`. Any other byte, including 0x1A, moves it to `RAM_LOCKED`.
- R3: A write with cpu_addr[15:14]=00 and cpu_addr[8]=1 loads wr_data[3:0] into the bank register. A value of 0 becomes 1. A value above ROM_BANKS-1 becomes ROM_BANKS-1.
- R4: With cpu_addr[15:14]=00, `rom_addr` equals {zeros, cpu_addr[13:0]}. `rom_rd` equals rd_en whenever cpu_addr[15]=0.
- R5: With cpu_addr[15:14]=01, `rom_addr` equals {bank, cpu_addr[13:0]}, where the bank occupies the top BANK_W bits.
- R6: Any access at cpu_addr>=0xA000 reaches RAM cell cpu_addr[8:0], so the RAM repeats every 512 bytes. A write stores wr_data[3:0]. A read while `RAM_OPEN` returns {4'hF, stored nibble} on `rd_data` in the next cycle.
- R7: If a cycle is not an enabled RAM read (this includes a RAM read while `RAM_LOCKED`), `rd_data` is 0xFF in the following cycle.
- R8: A RAM write while `RAM_LOCKED` leaves the cell unchanged.
- R9: Writes in 0x4000–0x9FFF change neither the bank register, the gate state nor the RAM.
- R10: `open_bus` is high exactly when rd_en is high and cpu_addr lies in 0x8000–0x9FFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| wr_data | input | 8 | CPU write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | RAM read data, one cycle after rd_en |
| rom_addr | output | BANK_W+14 | Physical ROM byte address |
| rom_rd | output | 1 | Read strobe toward the external ROM |
| open_bus | output | 1 | Read of the unmapped 0x8000–0x9FFF range |

## Verification
The bench builds the block with ROM_BANKS=8 and keeps BANK_W=4. With these values the 4-bit field can hold bank numbers 8 to 15, which lie above the limit. Writes of 9 and 0xF therefore exercise the saturation to 7. Writes of 0 and of 0x10 exercise the zero-to-one substitution. With the default of 16 banks, saturation could never occur.

// File: rtl/bankctl_pkg.sv
package bankctl_pkg;

    typedef enum logic [0:0] {
        RAM_LOCKED = 1'b0,
        RAM_OPEN   = 1'b1
    } gate_state_e;

    typedef enum logic [1:0] {
        RGN_ROM_FIXED  = 2'd0,
        RGN_ROM_BANKED = 2'd1,
        RGN_UNMAPPED   = 2'd2,
        RGN_RAM        = 2'd3
    } region_e;

    localparam logic [7:0] UNLOCK_CODE = 8'h0A;
    localparam int         PAGE_W      = 14;

    function automatic region_e region_of(input logic [15:0] a);
        if (a[15] == 1'b0)
            return a[14] ? RGN_ROM_BANKED : RGN_ROM_FIXED;
        else if (a[14:13] == 2'b00)
            return RGN_UNMAPPED;
        else
            return RGN_RAM;
    endfunction

endpackage

// File: rtl/bankctl_decode.sv
module bankctl_decode
    import bankctl_pkg::*;
(
    input  logic [15:0] cpu_addr,
    input  logic        wr_en,
    input  logic        rd_en,
    output logic        gate_wr,
    output logic        bank_wr,
    output logic        ram_hit,
    output logic        banked_sel,
    output logic        rom_rd,
    output logic        open_bus
);
    region_e rgn;

    always_comb begin
        rgn        = region_of(cpu_addr);
        gate_wr    = 1'b0;
        bank_wr    = 1'b0;
        ram_hit    = 1'b0;
        banked_sel = 1'b0;
        rom_rd     = 1'b0;
        open_bus   = 1'b0;
        unique case (rgn)
            RGN_ROM_FIXED: begin
                gate_wr = wr_en & ~cpu_addr[8];
                bank_wr = wr_en &  cpu_addr[8];
                rom_rd  = rd_en;
            end
            RGN_ROM_BANKED: begin
                banked_sel = 1'b1;
                rom_rd     = rd_en;
            end
            RGN_UNMAPPED: begin
                open_bus = rd_en;
            end
            RGN_RAM: begin
                ram_hit = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/bankctl_gate_fsm.sv
module bankctl_gate_fsm
    import bankctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       gate_wr,
    input  logic [7:0] wr_data,
    output logic       ram_on
);
    gate_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RAM_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RAM_LOCKED: if (gate_wr && wr_data == UNLOCK_CODE) state_d = RAM_OPEN;
            RAM_OPEN:   if (gate_wr && wr_data != UNLOCK_CODE) state_d = RAM_LOCKED;
        endcase
    end

    always_comb begin
        unique case (state_q)
            RAM_LOCKED: ram_on = 1'b0;
            RAM_OPEN:   ram_on = 1'b1;
        endcase
    end
endmodule

// File: rtl/bankctl_bank_reg.sv
module bankctl_bank_reg #(
    parameter int BANK_W    = 4,
    parameter int ROM_BANKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_wr,
    input  logic [BANK_W-1:0] bank_in,
    output logic [BANK_W-1:0] bank_q
);
    localparam int                FIELD_MAX = (1 << BANK_W) - 1;
    localparam logic [BANK_W-1:0] TOP_BANK  = BANK_W'(ROM_BANKS - 1);
    localparam logic [BANK_W-1:0] ONE       = BANK_W'(1);

    logic [BANK_W-1:0] nonzero;
    logic [BANK_W-1:0] clamped;

    assign nonzero = (bank_in == '0) ? ONE : bank_in;

    generate
        if (ROM_BANKS - 1 >= FIELD_MAX) begin : g_no_clamp
            assign clamped = nonzero;
        end else begin : g_clamp
            assign clamped = (nonzero > TOP_BANK) ? TOP_BANK : nonzero;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)       bank_q <= ONE;
        else if (bank_wr) bank_q <= clamped;
    end
endmodule

// File: rtl/bankctl_nibble_ram.sv
module bankctl_nibble_ram #(
    parameter int DEPTH = 512,
    parameter int CELL_W = 4
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic                     re,
    input  logic [$clog2(DEPTH)-1:0] idx,
    input  logic [CELL_W-1:0]        din,
    output logic [CELL_W-1:0]        dout
);
    logic [CELL_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[idx] <= din;
        if (re) dout <= cells[idx];
    end
endmodule

// File: rtl/nibble_bank_ctrl.sv
module nibble_bank_ctrl
    import bankctl_pkg::*;
#(
    parameter int BANK_W    = 4,
    parameter int ROM_BANKS = 16,
    parameter int RAM_DEPTH = 512
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [15:0]              cpu_addr,
    input  logic [7:0]               wr_data,
    input  logic                     wr_en,
    input  logic                     rd_en,
    output logic [7:0]               rd_data,
    output logic [BANK_W+PAGE_W-1:0] rom_addr,
    output logic                     rom_rd,
    output logic                     open_bus
);
    localparam int RAM_AW = $clog2(RAM_DEPTH);
    localparam int CELL_W = 4;

    logic              gate_wr, bank_wr, ram_hit, banked_sel;
    logic              ram_on;
    logic [BANK_W-1:0] bank_q;
    logic [CELL_W-1:0] nib_q;
    logic              rd_live_q;

    bankctl_decode u_dec (
        .cpu_addr  (cpu_addr),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .gate_wr   (gate_wr),
        .bank_wr   (bank_wr),
        .ram_hit   (ram_hit),
        .banked_sel(banked_sel),
        .rom_rd    (rom_rd),
        .open_bus  (open_bus)
    );

    bankctl_gate_fsm u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .gate_wr(gate_wr),
        .wr_data(wr_data),
        .ram_on (ram_on)
    );

    bankctl_bank_reg #(.BANK_W(BANK_W), .ROM_BANKS(ROM_BANKS)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .bank_wr(bank_wr),
        .bank_in(wr_data[BANK_W-1:0]),
        .bank_q (bank_q)
    );

    bankctl_nibble_ram #(.DEPTH(RAM_DEPTH), .CELL_W(CELL_W)) u_ram (
        .clk (clk),
        .we  (wr_en & ram_hit & ram_on),
        .re  (rd_en & ram_hit),
        .idx (cpu_addr[RAM_AW-1:0]),
        .din (wr_data[CELL_W-1:0]),
        .dout(nib_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) rd_live_q <= 1'b0;
        else        rd_live_q <= rd_en & ram_hit & ram_on;
    end

    assign rd_data  = rd_live_q ? {{(8-CELL_W){1'b1}}, nib_q} : 8'hFF;
    assign rom_addr = {(banked_sel ? bank_q : {BANK_W{1'b0}}), cpu_addr[PAGE_W-1:0]};
endmodule

// File: rtl/nibble_bank_ctrl_chk.sv
module nibble_bank_ctrl_chk #(
    parameter int BANK_W    = 4,
    parameter int ROM_BANKS = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [15:0]          cpu_addr,
    input logic [7:0]           wr_data,
    input logic                 wr_en,
    input logic                 rd_en,
    input logic [7:0]           rd_data,
    input logic [BANK_W+13:0]   rom_addr,
    input logic                 open_bus,
    input logic                 ram_on,
    input logic [BANK_W-1:0]    bank_q
);
    localparam logic [BANK_W-1:0] TOP_BANK = BANK_W'(ROM_BANKS - 1);

    // R3: the bank register never holds 0 and never exceeds the limit
    a_r3_bank_range: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q != '0) && (bank_q <= TOP_BANK));

    // R4: fixed window maps straight to page 0
    a_r4_fixed_page: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b00) |-> (rom_addr == {{BANK_W{1'b0}}, cpu_addr[13:0]}));

    // R5: banked window carries the bank register
    a_r5_banked_page: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b01) |-> (rom_addr[BANK_W+13:14] == bank_q));

    // R6: upper nibble of read data is always ones
    a_r6_upper_ones: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7:4] == 4'hF);

    // R7: a locked RAM read yields 0xFF next cycle
    a_r7_locked_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cpu_addr >= 16'hA000 && !ram_on) |=> (rd_data == 8'hFF));

    // R2, R9: gate state changes only after a gate write
    a_r9_gate_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && cpu_addr[15:14] == 2'b00 && !cpu_addr[8]) |=> $stable(ram_on));

    // R9: bank register changes only after a bank write
    a_r9_bank_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && cpu_addr[15:14] == 2'b00 && cpu_addr[8]) |=> $stable(bank_q));

    // R2: writing the unlock code opens the gate
    a_r2_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cpu_addr[15:14] == 2'b00 && !cpu_addr[8] && wr_data == 8'h0A) |=> ram_on);

    // R10: open bus only during a read
    a_r10_open_bus: assert property (@(posedge clk) disable iff (!rst_n)
        open_bus |-> (rd_en && cpu_addr[15:13] == 3'b100));
endmodule

bind nibble_bank_ctrl nibble_bank_ctrl_chk #(.BANK_W(BANK_W), .ROM_BANKS(ROM_BANKS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpu_addr(cpu_addr),
    .wr_data (wr_data),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .rom_addr(rom_addr),
    .open_bus(open_bus),
    .ram_on  (ram_on),
    .bank_q  (bank_q)
);

// File: tb/nibble_bank_ctrl_test.sv
module nibble_bank_ctrl_test;
    localparam int BW = 4;
    localparam int NB = 8;
    localparam int AW = BW + 14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   cpu_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [7:0]    rd_data;
    logic [AW-1:0] rom_addr;
    logic          rom_rd;
    logic          open_bus;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    nibble_bank_ctrl #(.BANK_W(BW), .ROM_BANKS(NB)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .wr_data(wr_data),
        .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .rom_addr(rom_addr),
        .rom_rd(rom_rd), .open_bus(open_bus)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ram_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic rom_probe(input logic [15:0] a, output logic [AW-1:0] ra,
                             output logic rr, output logic ob);
        @(negedge clk);
        cpu_addr = a; rd_en = 1'b1;
        #1;
        ra = rom_addr; rr = rom_rd; ob = open_bus;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic logic [AW-1:0] banked(input logic [3:0] b, input logic [15:0] a);
        return {b, a[13:0]};
    endfunction

    task automatic t_reset();
        logic [AW-1:0] ra; logic rr, ob; logic [7:0] d;
        check("R1 rd_data after reset", rd_data, 8'hFF);
        rom_probe(16'h4123, ra, rr, ob);
        check("R1 bank is 1 after reset", ra, banked(4'd1, 16'h4123));
        ram_read(16'hA000, d);
        check("R1 RAM locked after reset", d, 8'hFF);
    endtask

    task automatic t_fixed_rom();
        logic [AW-1:0] ra; logic rr, ob;
        rom_probe(16'h2ABC, ra, rr, ob);
        check("R4 fixed page address", ra, {4'd0, 14'h2ABC});
        check("R4 rom_rd in ROM window", rr, 1'b1);
    endtask

    task automatic t_bank_select();
        logic [AW-1:0] ra; logic rr, ob;
        bus_write(16'h0100, 8'h05);
        rom_probe(16'h7FFF, ra, rr, ob);
        check("R5 bank 5 address", ra, banked(4'd5, 16'h7FFF));
        bus_write(16'h3F00, 8'h13);
        rom_probe(16'h4000, ra, rr, ob);
        check("R3 low nibble only", ra, banked(4'd3, 16'h4000));
        bus_write(16'h0100, 8'h00);
        rom_probe(16'h4001, ra, rr, ob);
        check("R3 zero becomes one", ra, banked(4'd1, 16'h4001));
        bus_write(16'h0100, 8'h10);
        rom_probe(16'h4001, ra, rr, ob);
        check("R3 0x10 nibble zero becomes one", ra, banked(4'd1, 16'h4001));
    endtask

    task automatic t_bank_clamp();
        logic [AW-1:0] ra; logic rr, ob;
        bus_write(16'h0100, 8'h09);
        rom_probe(16'h5555, ra, rr, ob);
        check("R3 9 saturates to 7", ra, banked(4'd7, 16'h5555));
        bus_write(16'h01FF, 8'h0F);
        rom_probe(16'h5555, ra, rr, ob);
        check("R3 15 saturates to 7", ra, banked(4'd7, 16'h5555));
        bus_write(16'h0100, 8'h07);
        rom_probe(16'h5555, ra, rr, ob);
        check("R3 7 kept", ra, banked(4'd7, 16'h5555));
    endtask

    task automatic t_gate_and_ram();
        logic [7:0] d;
        bus_write(16'h0000, 8'h0A);
        bus_write(16'hA005, 8'h3C);
        ram_read(16'hA005, d);
        check("R6 nibble stored, upper ones", d, 8'hFC);
        ram_read(16'hBE05, d);
        check("R6 mirror at 0xBE05", d, 8'hFC);
        bus_write(16'hFFFF, 8'h97);
        ram_read(16'hA1FF, d);
        check("R6 mirror from 0xFFFF", d, 8'hF7);
        @(negedge clk);
        check("R7 idle cycle gives FF", rd_data, 8'hFF);
        bus_write(16'h2000, 8'h1A);
        ram_read(16'hA005, d);
        check("R2 0x1A locks RAM (R7 FF)", d, 8'hFF);
        bus_write(16'hA005, 8'h01);
        bus_write(16'h0000, 8'h0A);
        ram_read(16'hA005, d);
        check("R8 locked write ignored", d, 8'hFC);
    endtask

    task automatic t_ignored_writes();
        logic [AW-1:0] ra; logic rr, ob; logic [7:0] d;
        bus_write(16'h4100, 8'h03);
        bus_write(16'h6000, 8'h00);
        bus_write(16'h8005, 8'h00);
        rom_probe(16'h4000, ra, rr, ob);
        check("R9 bank unchanged", ra, banked(4'd7, 16'h4000));
        ram_read(16'hA005, d);
        check("R9 gate and RAM unchanged", d, 8'hFC);
        bus_write(16'h0000, 8'h00);
        bus_write(16'h6000, 8'h0A);
        ram_read(16'hA005, d);
        check("R9 high write does not unlock", d, 8'hFF);
    endtask

    task automatic t_open_bus();
        logic [AW-1:0] ra; logic rr, ob; logic [7:0] d;
        rom_probe(16'h9ABC, ra, rr, ob);
        check("R10 open_bus in 0x8000-0x9FFF", ob, 1'b1);
        check("R4 no rom_rd above 0x7FFF", rr, 1'b0);
        rom_probe(16'hA000, ra, rr, ob);
        check("R10 no open_bus in RAM window", ob, 1'b0);
        rom_probe(16'h1000, ra, rr, ob);
        check("R10 no open_bus in ROM window", ob, 1'b0);
        @(negedge clk);
        cpu_addr = 16'h8000;
        #1;
        check("R10 no open_bus without read", open_bus, 1'b0);
        ram_read(16'h8000, d);
        check("R7 unmapped read gives FF", d, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fixed_rom();
        t_bank_select();
        t_bank_clamp();
        t_gate_and_ram();
        t_ignored_writes();
        t_open_bus();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule